// File: doc/BRIEF.md
# Status Flag Condition Evaluator

This block keeps the single status flag of a small 4-bit controller. It decides whether a wake condition holds. A 4-bit operand selects that condition from three sources: the key-input pin levels, a timer zero indication and three auxiliary pins. The auxiliary pins are named aux0, aux1 and aux2. Each auxiliary pin is qualified by configuration bits of its port.

Three single-cycle strobes drive the block. The instruction decoder raises a condition-test strobe or a halt strobe, and the standby logic raises a wake strobe. A condition test loads the flag with the result of the evaluation. A halt uses the same evaluation to choose between updating the flag and asking the sequencer to enter standby. A wake always sets the flag. The standby gating, the timer and the decoder are outside this block.

Top module: `statusFlagUnit`

## Requirements
- R1: While reset is held and in the first cycle after it, `statusFlag` and `standbyReq` are both 0.
- R2: When `testStrobe` is high, `operand[3]` is 0 and `operand[2:0]` is 000, 011 or 110, the flag takes the OR of all `keyLevels` bits at the next clock edge.
- R3: When `testStrobe` is high, `operand[3]` is 0 and `operand[2:0]` is 101, the flag takes the value of `timerZero` at the next clock edge.
- R4: When `testStrobe` is high, `operand[3]` is 0 and `operand[2:0]` is 001, 010, 100 or 111, the flag is cleared, whatever the key and timer levels are.
- R5: When `operand[3]` is 1, the pin term is ORed with the condition selected by the low bits. In the pin term, `auxLevels[0]` and `auxLevels[1]` count only while `portCfg[2]` is 0 and `portCfg[0]` is 1.
- R6: `auxLevels[2]` counts in the pin term only while `portCfg[3]` is 1.
- R7: A halt whose condition holds sets the flag to 1 and leaves `standbyReq` at 0.
- R8: A halt with the flag at 1 and its condition false clears the flag and leaves `standbyReq` at 0.
- R9: A halt with the flag at 0 and its condition false keeps the flag at 0 and raises `standbyReq` for exactly one cycle after the edge.
- R10: A `wakeStrobe` sets the flag to 1 at the next edge.
- R11: When strobes coincide, wake wins over halt, and halt wins over condition test.
- R12: In a cycle with no strobe, the flag keeps its value, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyLevels | input | KEY_W | Key-input pin levels |
| auxLevels | input | 3 | Auxiliary pin levels: bit 0 = aux0, bit 1 = aux1, bit 2 = aux2 |
| portCfg | input | 4 | Port configuration: bit 0 = 1 and bit 2 = 0 make aux0/aux1 inputs; bit 3 enables aux2 as a wake source |
| timerZero | input | 1 | Timer down counter is at zero |
| operand | input | 4 | Condition selector for test and halt |
| testStrobe | input | 1 | Condition-test instruction executes |
| haltStrobe | input | 1 | Halt instruction executes |
| wakeStrobe | input | 1 | Standby has been released |
| statusFlag | output | 1 | Status flag |
| standbyReq | output | 1 | One-cycle request to enter standby |

## Verification
Some rules can be checked on every cycle. These are the one-cycle length of the standby request, and that a request only follows a halt taken while the flag was 0. The assertions also check that a wake always sets the flag, that a halt with the flag at 1 never requests standby, and that the flag holds in idle cycles. Only the bench scenarios can show that the operand decode is correct. This covers which codes select the keys, which select the timer, which select nothing, and the qualification of each auxiliary pin by its configuration bits. The scenarios are also needed to show how the priority resolves when strobes coincide.

// File: rtl/sfePkg.sv
package sfePkg;

  // Which base source the low three operand bits select
  typedef enum logic [1:0] {
    BASE_NONE  = 2'd0,
    BASE_KEYS  = 2'd1,
    BASE_TIMER = 2'd2
  } baseSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCond;   // flag <= evaluated condition
    logic forceSet;   // flag <= 1
    logic forceClr;   // flag <= 0
  } flagCmd_t;

  localparam int OPERAND_W = 4;
  localparam int AUX_W     = 3;
  localparam int CFG_W     = 4;

  // Low-three-bit codes
  localparam logic [2:0] CODE_KEYS_A = 3'b000;
  localparam logic [2:0] CODE_KEYS_B = 3'b011;
  localparam logic [2:0] CODE_KEYS_C = 3'b110;
  localparam logic [2:0] CODE_TIMER  = 3'b101;

  // Configuration bit positions
  localparam int CFG_AUX01_IN  = 0;  // must be 1
  localparam int CFG_AUX01_OUT = 2;  // must be 0
  localparam int CFG_AUX2_EN   = 3;  // must be 1

  // Operand bit that adds the auxiliary pin term
  localparam int OP_PIN_BIT = 3;

  function automatic baseSel_t decodeBase(input logic [2:0] code);
    case (code)
      CODE_KEYS_A, CODE_KEYS_B, CODE_KEYS_C: decodeBase = BASE_KEYS;
      CODE_TIMER:                            decodeBase = BASE_TIMER;
      default:                               decodeBase = BASE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sfeDatapath.sv
module sfeDatapath
  import sfePkg::*;
#(
  parameter int KEY_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_W-1:0]     keyLevels,
  input  logic [AUX_W-1:0]     auxLevels,
  input  logic [CFG_W-1:0]     portCfg,
  input  logic                 timerZero,
  input  logic [OPERAND_W-1:0] operand,
  input  flagCmd_t             cmd,
  output logic                 condMet,
  output logic                 flagQ
);

  localparam int AUX01_N = 2;

  baseSel_t           baseSel;
  logic               anyKey;
  logic               baseTerm;
  logic               aux01Qual;
  logic [AUX_W-1:0]   auxQualified;
  logic               pinTerm;

  assign anyKey  = |keyLevels;
  assign baseSel = decodeBase(operand[2:0]);

  always_comb begin
    unique case (baseSel)
      BASE_KEYS:  baseTerm = anyKey;
      BASE_TIMER: baseTerm = timerZero;
      default:    baseTerm = 1'b0;
    endcase
  end

  // aux0/aux1 are only inputs with the direction bits in the right state
  assign aux01Qual = portCfg[CFG_AUX01_IN] & ~portCfg[CFG_AUX01_OUT];

  genvar gi;
  generate
    for (gi = 0; gi < AUX_W; gi++) begin : gAuxQual
      if (gi < AUX01_N) begin : gDir
        assign auxQualified[gi] = auxLevels[gi] & aux01Qual;
      end else begin : gEn
        assign auxQualified[gi] = auxLevels[gi] & portCfg[CFG_AUX2_EN];
      end
    end
  endgenerate

  assign pinTerm = operand[OP_PIN_BIT] & (|auxQualified);
  assign condMet = baseTerm | pinTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (cmd.forceSet) begin
      flagQ <= 1'b1;
    end else if (cmd.forceClr) begin
      flagQ <= 1'b0;
    end else if (cmd.loadCond) begin
      flagQ <= condMet;
    end
  end

endmodule

// File: rtl/sfeControl.sv
module sfeControl
  import sfePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     testStrobe,
  input  logic     haltStrobe,
  input  logic     wakeStrobe,
  input  logic     flagQ,
  input  logic     condMet,
  output flagCmd_t cmd,
  output logic     standbyReq
);

  logic enterStandby;

  // Priority: wake, then halt, then test
  always_comb begin
    cmd          = '0;
    enterStandby = 1'b0;
    if (wakeStrobe) begin
      cmd.forceSet = 1'b1;
    end else if (haltStrobe) begin
      if (condMet) begin
        cmd.forceSet = 1'b1;
      end else if (flagQ) begin
        cmd.forceClr = 1'b1;
      end else begin
        enterStandby = 1'b1;
      end
    end else if (testStrobe) begin
      cmd.loadCond = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      standbyReq <= 1'b0;
    end else begin
      standbyReq <= enterStandby;
    end
  end

endmodule

// File: rtl/statusFlagUnit.sv
module statusFlagUnit
  import sfePkg::*;
#(
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEY_W-1:0] keyLevels,
  input  logic [2:0]       auxLevels,
  input  logic [3:0]       portCfg,
  input  logic             timerZero,
  input  logic [3:0]       operand,
  input  logic             testStrobe,
  input  logic             haltStrobe,
  input  logic             wakeStrobe,
  output logic             statusFlag,
  output logic             standbyReq
);

  flagCmd_t cmd;
  logic     condMet;
  logic     flagQ;

  sfeDatapath #(.KEY_W(KEY_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .keyLevels (keyLevels),
    .auxLevels (auxLevels),
    .portCfg   (portCfg),
    .timerZero (timerZero),
    .operand   (operand),
    .cmd       (cmd),
    .condMet   (condMet),
    .flagQ     (flagQ)
  );

  sfeControl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .testStrobe (testStrobe),
    .haltStrobe (haltStrobe),
    .wakeStrobe (wakeStrobe),
    .flagQ      (flagQ),
    .condMet    (condMet),
    .cmd        (cmd),
    .standbyReq (standbyReq)
  );

  assign statusFlag = flagQ;

endmodule

// File: rtl/sfeChecker.sv
module sfeChecker (
  input logic clk,
  input logic rstN,
  input logic testStrobe,
  input logic haltStrobe,
  input logic wakeStrobe,
  input logic statusFlag,
  input logic standbyReq
);

  AST_STANDBY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |=> !standbyReq); // R9

  AST_STANDBY_FROM_HALT: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |-> ($past(haltStrobe) && !$past(wakeStrobe) && !$past(statusFlag))); // R9

  AST_STANDBY_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |-> !statusFlag); // R9

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |=> statusFlag); // R10

  AST_HALT_FLAG_HIGH_NO_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    (haltStrobe && statusFlag) |=> !standbyReq); // R8

  AST_TEST_NO_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    (testStrobe && !haltStrobe) |=> !standbyReq); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!testStrobe && !haltStrobe && !wakeStrobe) |=> $stable(statusFlag)); // R12

endmodule

bind statusFlagUnit sfeChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .testStrobe (testStrobe),
  .haltStrobe (haltStrobe),
  .wakeStrobe (wakeStrobe),
  .statusFlag (statusFlag),
  .standbyReq (standbyReq)
);

// File: tb/statusFlagUnit_bench.sv
module statusFlagUnit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int KEY_W      = 4;
  localparam int NVEC       = 20;
  localparam int WATCHDOG   = 20000;

  logic             clk = 1'b0;
  logic             rstN;
  logic [KEY_W-1:0] keyLevels;
  logic [2:0]       auxLevels;
  logic [3:0]       portCfg;
  logic             timerZero;
  logic [3:0]       operand;
  logic             testStrobe, haltStrobe, wakeStrobe;
  logic             statusFlag, standbyReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusFlagUnit #(.KEY_W(KEY_W)) u_statusFlagUnit (
    .clk(clk), .rstN(rstN), .keyLevels(keyLevels), .auxLevels(auxLevels),
    .portCfg(portCfg), .timerZero(timerZero), .operand(operand),
    .testStrobe(testStrobe), .haltStrobe(haltStrobe), .wakeStrobe(wakeStrobe),
    .statusFlag(statusFlag), .standbyReq(standbyReq)
  );

  // Fields: op[20:17] keys[16:13] aux[12:10] cfg[9:6] tz[5] exp[4] req[3:0]
  localparam logic [20:0] VEC [NVEC] = '{
    {4'b0000, 4'b0001, 3'b000, 4'b0000, 1'b0, 1'b1, 4'd2},  // R2 code 000 key high
    {4'b0000, 4'b0000, 3'b111, 4'b1001, 1'b1, 1'b0, 4'd2},  // R2 no key
    {4'b0011, 4'b1000, 3'b000, 4'b0000, 1'b0, 1'b1, 4'd2},  // R2 code 011
    {4'b0110, 4'b0100, 3'b000, 4'b0000, 1'b0, 1'b1, 4'd2},  // R2 code 110
    {4'b0110, 4'b0000, 3'b000, 4'b0000, 1'b1, 1'b0, 4'd2},  // R2 timer ignored
    {4'b0101, 4'b0000, 3'b000, 4'b0000, 1'b1, 1'b1, 4'd3},  // R3 timer zero
    {4'b0101, 4'b1111, 3'b000, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3 keys ignored
    {4'b0001, 4'b1111, 3'b000, 4'b0000, 1'b1, 1'b0, 4'd4},  // R4 code 001
    {4'b0010, 4'b1111, 3'b000, 4'b0000, 1'b1, 1'b0, 4'd4},  // R4 code 010
    {4'b0100, 4'b1111, 3'b000, 4'b0000, 1'b1, 1'b0, 4'd4},  // R4 code 100
    {4'b0111, 4'b1111, 3'b000, 4'b0000, 1'b1, 1'b0, 4'd4},  // R4 code 111
    {4'b1001, 4'b0000, 3'b001, 4'b0001, 1'b0, 1'b1, 4'd5},  // R5 aux0 as input
    {4'b1001, 4'b0000, 3'b010, 4'b0001, 1'b0, 1'b1, 4'd5},  // R5 aux1 as input
    {4'b1001, 4'b0000, 3'b011, 4'b0101, 1'b0, 1'b0, 4'd5},  // R5 cfg bit2 set
    {4'b1001, 4'b0000, 3'b011, 4'b0000, 1'b0, 1'b0, 4'd5},  // R5 cfg bit0 clear
    {4'b0001, 4'b0000, 3'b011, 4'b0001, 1'b0, 1'b0, 4'd5},  // R5 operand bit3 clear
    {4'b1101, 4'b0000, 3'b001, 4'b0001, 1'b0, 1'b1, 4'd5},  // R5 ORed onto timer code
    {4'b1001, 4'b0000, 3'b100, 4'b1000, 1'b0, 1'b1, 4'd6},  // R6 aux2 enabled
    {4'b1001, 4'b0000, 3'b100, 4'b0001, 1'b0, 1'b0, 4'd6},  // R6 aux2 disabled
    {4'b1000, 4'b0000, 3'b100, 4'b1000, 1'b0, 1'b1, 4'd6}   // R6 with key code, no key
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    testStrobe = 0; haltStrobe = 0; wakeStrobe = 0;
  endtask

  // Drive one strobe cycle starting at a negedge; returns at the next negedge
  task automatic pulse(input logic t, input logic h, input logic w);
    testStrobe = t; haltStrobe = h; wakeStrobe = w;
    @(negedge clk);
    idle();
  endtask

  task automatic setInputs(input logic [3:0] op, input logic [KEY_W-1:0] k,
                           input logic [2:0] a, input logic [3:0] c, input logic tz);
    operand = op; keyLevels = k; auxLevels = a; portCfg = c; timerZero = tz;
  endtask

  // Force flag to a known value through the normal interface
  task automatic forceFlag(input logic v);
    if (v) begin
      pulse(0, 0, 1);
    end else begin
      setInputs(4'b0001, '0, 3'b000, 4'b0000, 1'b0);
      pulse(1, 0, 0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    rstN = 0;
    idle();
    setInputs(4'b0000, '1, 3'b111, 4'b1001, 1'b1);
    repeat (3) @(negedge clk);
    check("R1", statusFlag, 1'b0, "flag in reset");
    check("R1", standbyReq, 1'b0, "standbyReq in reset");
    rstN = 1;
    @(negedge clk);
    check("R1", statusFlag, 1'b0, "flag after reset");
    check("R1", standbyReq, 1'b0, "standbyReq after reset");

    // Table walk with the condition-test strobe
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      string tag;
      v = VEC[i];
      forceFlag(~v[4]);  // start from opposite value
      setInputs(v[20:17], v[16:13], v[12:10], v[9:6], v[5]);
      pulse(1, 0, 0);
      tag = $sformatf("R%0d", v[3:0]);
      check(tag, statusFlag, v[4], $sformatf("vector %0d flag", i));
    end

    // R7: halt with condition true sets flag, no standby
    forceFlag(0);
    setInputs(4'b0000, 4'b0010, 3'b000, 4'b0000, 1'b0);
    pulse(0, 1, 0);
    check("R7", statusFlag, 1'b1, "halt cond true flag");
    check("R7", standbyReq, 1'b0, "halt cond true standbyReq");

    // R8: flag 1, condition false -> clear, no standby
    forceFlag(1);
    setInputs(4'b0001, 4'b1111, 3'b000, 4'b0000, 1'b1);
    pulse(0, 1, 0);
    check("R8", statusFlag, 1'b0, "halt flag1 cond false flag");
    check("R8", standbyReq, 1'b0, "halt flag1 cond false standbyReq");

    // R9: flag 0, condition false -> one-cycle standby request
    forceFlag(0);
    setInputs(4'b0000, 4'b0000, 3'b000, 4'b0000, 1'b0);
    pulse(0, 1, 0);
    check("R9", standbyReq, 1'b1, "standbyReq after halt");
    check("R9", statusFlag, 1'b0, "flag stays 0");
    @(negedge clk);
    check("R9", standbyReq, 1'b0, "standbyReq drops after one cycle");

    // R10: wake sets flag
    forceFlag(0);
    pulse(0, 0, 1);
    check("R10", statusFlag, 1'b1, "wake sets flag");

    // R11: wake beats halt (would otherwise request standby)
    forceFlag(0);
    setInputs(4'b0000, 4'b0000, 3'b000, 4'b0000, 1'b0);
    pulse(0, 1, 1);
    check("R11", statusFlag, 1'b1, "wake+halt flag");
    check("R11", standbyReq, 1'b0, "wake+halt standbyReq");
    // R11: halt beats test
    forceFlag(0);
    setInputs(4'b0000, 4'b0000, 3'b000, 4'b0000, 1'b0);
    pulse(1, 1, 0);
    check("R11", standbyReq, 1'b1, "halt+test standbyReq");
    // R11: wake beats test with false condition
    forceFlag(0);
    setInputs(4'b0001, 4'b0000, 3'b000, 4'b0000, 1'b0);
    pulse(1, 0, 1);
    check("R11", statusFlag, 1'b1, "wake+test flag");

    // R12: idle cycles hold the flag while inputs move
    forceFlag(1);
    setInputs(4'b0001, 4'b0000, 3'b000, 4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    check("R12", statusFlag, 1'b1, "flag holds 1 when idle");
    forceFlag(0);
    setInputs(4'b1000, 4'b1111, 3'b111, 4'b1001, 1'b1);
    repeat (3) @(negedge clk);
    check("R12", statusFlag, 1'b0, "flag holds 0 when idle");
    check("R12", standbyReq, 1'b0, "no standbyReq when idle");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule